// File: doc/BRIEF.md
# Interrupt Priority and Delegation Resolver

This combinational block decides which interrupt a hart takes next and at which privilege level that interrupt is serviced. It looks at the pending and enable masks, at the delegation masks at machine level and at supervisor level, at the current privilege and at the global interrupt-enable bits of the three levels. From these it produces a single selection, or it reports that no interrupt is taken.

Delegation is resolved level by level before any prioritisation. Machine level keeps the bits it does not delegate. Supervisor level receives the bits that machine level hands down and keeps the ones it does not delegate further. User level receives whatever supervisor level passes on. Whether a level may take its bits depends on how the current privilege compares with that level, and not only on that level's enable bit. Only the set at the winning level goes through a fixed priority encoder. Three parameters describe the hart: `HAS_SMODE`, `HAS_UMODE` and `HAS_UIRQ`, the last meaning that interrupts can be taken at user level.

Top module: `irq_resolve`

Interrupt numbering (bit positions in every mask and values of the cause code): USI=0, SSI=1, MSI=3, UTI=4, STI=5, MTI=7, UEI=8, SEI=9, MEI=11. Privilege encoding: U=0, S=1, M=3.

## Requirements
- R1: When pending & enable is zero, no interrupt is reported, even if delegated pending bits exist.
- R2: Machine level takes pending & enable & ~mDeleg when that set is non-zero and machine level is enabled, with target 3. This holds even when a higher-priority interrupt is delegated away.
- R3: Machine level is enabled when the current privilege is not 3, or when it is 3 and mIe=1.
- R4: If machine level takes nothing, the set pending & mDeleg is handed to supervisor level. Supervisor level takes (that set) & enable & ~sDeleg, with target 1, when that set is non-zero and supervisor level is enabled.
- R5: Supervisor level is enabled only if the current privilege is 0, or if it is 1 and sIe=1.
- R6: If supervisor level takes nothing, the bits it delegates (handed-down set & sDeleg) are taken at user level, with target 0, when user level is enabled. Otherwise nothing is reported.
- R7: User level is enabled only when HAS_UIRQ=1, the current privilege is 0 and uIe=1.
- R8: Within the chosen set, the cause is the highest-priority bit in the order MEI(11), MSI(3), MTI(7), SEI(9), SSI(1), STI(5), UEI(8), USI(0), UTI(4). Bits 2, 6 and 10 are never selected.
- R9: With HAS_UMODE=0, or with both HAS_SMODE=0 and HAS_UIRQ=0, delegation and the enable bits are skipped. The cause is chosen from pending & enable and the target is 3.
- R10: With HAS_SMODE=0 (user mode and user interrupts present), bits delegated by machine level go directly to user level when user level is enabled, and are dropped otherwise.
- R11: When irqValid is 0, irqCause and irqTarget are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pendIrq | input | 12 | Pending interrupt mask |
| enIrq | input | 12 | Interrupt enable mask |
| mDeleg | input | 12 | Machine-level delegation mask |
| sDeleg | input | 12 | Supervisor-level delegation mask |
| curPriv | input | 2 | Current privilege (U=0, S=1, M=3) |
| mIe | input | 1 | Machine global interrupt enable |
| sIe | input | 1 | Supervisor global interrupt enable |
| uIe | input | 1 | User global interrupt enable |
| irqValid | output | 1 | An interrupt is taken |
| irqCause | output | 4 | Cause code of the taken interrupt |
| irqTarget | output | 2 | Privilege that services it |

## Verification
The bench targets the fast-path exit: a design that skipped it would take delegated bits whose enables are clear. It also checks that prioritisation happens only after delegation. A design that encoded first would report a delegated MEI at the wrong level instead of the machine timer that machine level keeps. Further cases cover the privilege-relative enables, where a supervisor interrupt must be taken while running in user mode even with sIe=0. Each of the three hart configurations is run on inputs that separate them: a no-supervisor hart must send machine-delegated bits straight to user level, and a bypass hart must ignore mIe.

// File: rtl/irq_resolve_pkg.sv
package irq_resolve_pkg;

  localparam int IRQ_W     = 12;
  localparam int CAUSE_W   = 4;
  localparam int NUM_SRC   = 9;
  localparam int NUM_STAGE = 2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef logic [IRQ_W-1:0] irqVec_t;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic bypass;   // flat machine-only resolution
    logic useS;     // supervisor stage exists in the chain
    logic mEn;      // machine level may take its bits
    logic sEn;      // supervisor level may take its bits
    logic uEn;      // user level may take its bits
  } ctrlStrobes_t;

  // rank 0 is the highest priority; levels M, S, U in turn,
  // and within a level: external, software, timer
  function automatic logic [CAUSE_W-1:0] prioCode(input int rank);
    int lvl;
    int kind;
    logic [CAUSE_W-1:0] base;
    logic [CAUSE_W-1:0] offs;
    lvl  = rank / 3;
    kind = rank % 3;
    base = (lvl == 0) ? 4'd3 : ((lvl == 1) ? 4'd1 : 4'd0);
    offs = (kind == 0) ? 4'd8 : ((kind == 1) ? 4'd0 : 4'd4);
    return base + offs;
  endfunction

endpackage

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_resolve_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_UMODE = 1'b1,
  parameter bit HAS_UIRQ  = 1'b1
) (
  input  logic [1:0]   curPriv,
  input  logic         mIe,
  input  logic         sIe,
  input  logic         uIe,
  output ctrlStrobes_t strobes
);

  localparam bit FLAT = !HAS_UMODE || (!HAS_SMODE && !HAS_UIRQ);

  logic inM;
  logic inS;
  logic inU;

  assign inM = (curPriv == PRIV_M);
  assign inS = (curPriv == PRIV_S);
  assign inU = (curPriv == PRIV_U);

  always_comb begin
    strobes        = '0;
    strobes.bypass = FLAT;
    strobes.useS   = HAS_SMODE;
    // a level above the current privilege is always open
    strobes.mEn    = !inM || mIe;
    strobes.sEn    = HAS_SMODE && (inU || (inS && sIe));
    strobes.uEn    = HAS_UIRQ && inU && uIe;
  end

endmodule

// File: rtl/irq_level_stage.sv
module irq_level_stage
  import irq_resolve_pkg::*;
(
  input  irqVec_t inVec,
  input  irqVec_t enVec,
  input  irqVec_t delegVec,
  input  logic    levelEn,
  output irqVec_t takeVec,
  output irqVec_t passVec,
  output logic    take,
  output logic    pass
);

  assign takeVec = inVec & enVec & ~delegVec;
  assign passVec = inVec & delegVec;
  assign take    = levelEn && (takeVec != '0);
  assign pass    = (passVec != '0);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_resolve_pkg::*;
(
  input  irqVec_t              vec,
  output logic                 hit,
  output logic [CAUSE_W-1:0]   code
);

  always_comb begin
    hit  = 1'b0;
    code = '0;
    // walk from lowest to highest rank so the highest wins
    for (int r = NUM_SRC - 1; r >= 0; r--) begin
      if (vec[prioCode(r)]) begin
        hit  = 1'b1;
        code = prioCode(r);
      end
    end
  end

endmodule

// File: rtl/irq_deleg_path.sv
module irq_deleg_path
  import irq_resolve_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  irqVec_t      pendIrq,
  input  irqVec_t      enIrq,
  input  irqVec_t      mDeleg,
  input  irqVec_t      sDeleg,
  input  ctrlStrobes_t strobes,
  output irqVec_t      chosenVec,
  output logic [1:0]   chosenPriv,
  output logic         chosenAny
);

  irqVec_t stageIn   [NUM_STAGE];
  irqVec_t stageDel  [NUM_STAGE];
  logic    stageEn   [NUM_STAGE];
  irqVec_t takeVec   [NUM_STAGE];
  irqVec_t passVec   [NUM_STAGE];
  logic    take      [NUM_STAGE];
  logic    pass      [NUM_STAGE];

  irqVec_t effPend;
  irqVec_t uCand;
  logic    uCandAny;
  logic    sTake;

  assign effPend     = pendIrq & enIrq;
  assign stageIn[0]  = pendIrq;
  assign stageDel[0] = mDeleg;
  assign stageEn[0]  = strobes.mEn;
  assign stageDel[1] = sDeleg;
  assign stageEn[1]  = strobes.sEn;

  // chain: each stage sees what the stage above hands down
  for (genvar gi = 0; gi < NUM_STAGE; gi++) begin : g_stage
    if (gi > 0) begin : g_link
      assign stageIn[gi] = passVec[gi-1];
    end
    irq_level_stage u_stage (
      .inVec    (stageIn[gi]),
      .enVec    (enIrq),
      .delegVec (stageDel[gi]),
      .levelEn  (stageEn[gi]),
      .takeVec  (takeVec[gi]),
      .passVec  (passVec[gi]),
      .take     (take[gi]),
      .pass     (pass[gi])
    );
  end

  // hand-off to user level depends on whether S exists
  if (HAS_SMODE) begin : g_sChain
    assign sTake    = take[1];
    assign uCand    = passVec[1];
    assign uCandAny = pass[1];
  end else begin : g_noS
    assign sTake    = 1'b0;
    assign uCand    = passVec[0];
    assign uCandAny = pass[0];
  end

  always_comb begin
    chosenVec  = '0;
    chosenPriv = PRIV_U;
    chosenAny  = 1'b0;
    if (effPend == '0) begin
      chosenAny = 1'b0;
    end else if (strobes.bypass) begin
      chosenVec  = effPend;
      chosenPriv = PRIV_M;
      chosenAny  = 1'b1;
    end else if (take[0]) begin
      chosenVec  = takeVec[0];
      chosenPriv = PRIV_M;
      chosenAny  = 1'b1;
    end else if (pass[0]) begin
      if (strobes.useS && sTake) begin
        chosenVec  = takeVec[1];
        chosenPriv = PRIV_S;
        chosenAny  = 1'b1;
      end else if (uCandAny && strobes.uEn) begin
        chosenVec  = uCand;
        chosenPriv = PRIV_U;
        chosenAny  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import irq_resolve_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_UMODE = 1'b1,
  parameter bit HAS_UIRQ  = 1'b1
) (
  input  logic [11:0] pendIrq,
  input  logic [11:0] enIrq,
  input  logic [11:0] mDeleg,
  input  logic [11:0] sDeleg,
  input  logic [1:0]  curPriv,
  input  logic        mIe,
  input  logic        sIe,
  input  logic        uIe,
  output logic        irqValid,
  output logic [3:0]  irqCause,
  output logic [1:0]  irqTarget
);

  ctrlStrobes_t       strobes;
  irqVec_t            chosenVec;
  logic [1:0]         chosenPriv;
  logic               chosenAny;
  logic               hit;
  logic [CAUSE_W-1:0] code;

  irq_level_ctrl #(
    .HAS_SMODE (HAS_SMODE),
    .HAS_UMODE (HAS_UMODE),
    .HAS_UIRQ  (HAS_UIRQ)
  ) u_ctrl (
    .curPriv (curPriv),
    .mIe     (mIe),
    .sIe     (sIe),
    .uIe     (uIe),
    .strobes (strobes)
  );

  irq_deleg_path #(
    .HAS_SMODE (HAS_SMODE)
  ) u_path (
    .pendIrq    (pendIrq),
    .enIrq      (enIrq),
    .mDeleg     (mDeleg),
    .sDeleg     (sDeleg),
    .strobes    (strobes),
    .chosenVec  (chosenVec),
    .chosenPriv (chosenPriv),
    .chosenAny  (chosenAny)
  );

  irq_prio_enc u_enc (
    .vec  (chosenVec),
    .hit  (hit),
    .code (code)
  );

  assign irqValid  = chosenAny && hit;
  assign irqCause  = irqValid ? code : '0;
  assign irqTarget = irqValid ? chosenPriv : PRIV_U;

endmodule

// File: rtl/irq_resolve_chk.sv
module irq_resolve_chk (
  input logic [11:0] pendIrq,
  input logic [11:0] enIrq,
  input logic [1:0]  curPriv,
  input logic        sIe,
  input logic        uIe,
  input logic        irqValid,
  input logic [3:0]  irqCause,
  input logic [1:0]  irqTarget
);

  always_comb begin
    // R1
    none_when_idle_chk: assert (!irqValid || ((pendIrq & enIrq) != '0));
    // R11
    quiet_outputs_chk: assert (irqValid || (irqCause == 4'd0 && irqTarget == 2'd0));
    // R8
    cause_pending_chk: assert (!irqValid || (irqCause < 4'd12 && pendIrq[irqCause]));
    // R2
    m_take_enabled_chk: assert (!(irqValid && irqTarget == 2'd3)
                                || (irqCause < 4'd12 && enIrq[irqCause]));
    // R5
    s_gate_chk: assert (!(irqValid && irqTarget == 2'd1)
                        || curPriv == 2'd0 || (curPriv == 2'd1 && sIe));
    // R7
    u_gate_chk: assert (!(irqValid && irqTarget == 2'd0) || (curPriv == 2'd0 && uIe));
    // R3
    no_downward_chk: assert (!irqValid || curPriv == 2'd2 || irqTarget >= curPriv);
  end

endmodule

bind irq_resolve irq_resolve_chk u_chk (
  .pendIrq   (pendIrq),
  .enIrq     (enIrq),
  .curPriv   (curPriv),
  .sIe       (sIe),
  .uIe       (uIe),
  .irqValid  (irqValid),
  .irqCause  (irqCause),
  .irqTarget (irqTarget)
);

// File: tb/sim_irq_resolve.sv
`timescale 1ns/1ps
module sim_irq_resolve;

  localparam logic [11:0] B_USI = 12'h001, B_SSI = 12'h002, B_MSI = 12'h008;
  localparam logic [11:0] B_UTI = 12'h010, B_STI = 12'h020, B_MTI = 12'h080;
  localparam logic [11:0] B_UEI = 12'h100, B_SEI = 12'h200, B_MEI = 12'h800;
  localparam logic [11:0] ALL   = 12'hFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [11:0] pendIrq = '0, enIrq = '0, mDeleg = '0, sDeleg = '0;
  logic [1:0]  curPriv = '0;
  logic        mIe = 1'b0, sIe = 1'b0, uIe = 1'b0;

  logic       v0, v1, v2;
  logic [3:0] c0, c1, c2;
  logic [1:0] t0, t1, t2;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  irq_resolve #(.HAS_SMODE(1'b1), .HAS_UMODE(1'b1), .HAS_UIRQ(1'b1)) u0 (
    .pendIrq(pendIrq), .enIrq(enIrq), .mDeleg(mDeleg), .sDeleg(sDeleg),
    .curPriv(curPriv), .mIe(mIe), .sIe(sIe), .uIe(uIe),
    .irqValid(v0), .irqCause(c0), .irqTarget(t0));

  irq_resolve #(.HAS_SMODE(1'b1), .HAS_UMODE(1'b0), .HAS_UIRQ(1'b0)) u1 (
    .pendIrq(pendIrq), .enIrq(enIrq), .mDeleg(mDeleg), .sDeleg(sDeleg),
    .curPriv(curPriv), .mIe(mIe), .sIe(sIe), .uIe(uIe),
    .irqValid(v1), .irqCause(c1), .irqTarget(t1));

  irq_resolve #(.HAS_SMODE(1'b0), .HAS_UMODE(1'b1), .HAS_UIRQ(1'b1)) u2 (
    .pendIrq(pendIrq), .enIrq(enIrq), .mDeleg(mDeleg), .sDeleg(sDeleg),
    .curPriv(curPriv), .mIe(mIe), .sIe(sIe), .uIe(uIe),
    .irqValid(v2), .irqCause(c2), .irqTarget(t2));

  task automatic drive(input logic [11:0] p, input logic [11:0] e,
                       input logic [11:0] md, input logic [11:0] sd,
                       input logic [1:0] pr, input logic mi, input logic si, input logic ui);
    @(negedge clk);
    pendIrq = p; enIrq = e; mDeleg = md; sDeleg = sd;
    curPriv = pr; mIe = mi; sIe = si; uIe = ui;
    #2;
  endtask

  task automatic compare(input string req, input logic av, input logic [3:0] ac,
                         input logic [1:0] at, input logic ev, input logic [3:0] ec,
                         input logic [1:0] et);
    compared++;
    if (av !== ev || ac !== ec || at !== et) begin
      mismatched++;
      $display("FAIL %s: got valid=%0d cause=%0d target=%0d, expected valid=%0d cause=%0d target=%0d",
               req, av, ac, at, ev, ec, et);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    compare("R11 reset", v0, c0, t0, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_fast_path;
    drive(B_MEI, '0, B_MEI, '0, 2'd3, 1'b1, 1'b0, 1'b0);
    compare("R1 nothing enabled", v0, c0, t0, 1'b0, 4'd0, 2'd0);
    drive(B_SSI, '0, B_SSI, B_SSI, 2'd0, 1'b1, 1'b1, 1'b1);
    compare("R1 delegated but disabled", v0, c0, t0, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_machine;
    drive(B_MTI | B_MSI, ALL, '0, '0, 2'd3, 1'b1, 1'b0, 1'b0);
    compare("R2 machine takes", v0, c0, t0, 1'b1, 4'd3, 2'd3);
    drive(B_MTI, ALL, '0, '0, 2'd3, 1'b0, 1'b0, 1'b0);
    compare("R3 mIe clear in M", v0, c0, t0, 1'b0, 4'd0, 2'd0);
    drive(B_MTI, ALL, '0, '0, 2'd1, 1'b0, 1'b0, 1'b0);
    compare("R3 open from S", v0, c0, t0, 1'b1, 4'd7, 2'd3);
    drive(B_MEI | B_MTI, ALL, B_MEI, '0, 2'd1, 1'b0, 1'b1, 1'b0);
    compare("R2 delegation before priority", v0, c0, t0, 1'b1, 4'd7, 2'd3);
  endtask

  task automatic t_priority;
    drive(12'hBBB, ALL, '0, '0, 2'd3, 1'b1, 1'b0, 1'b0);
    compare("R8 all pending", v0, c0, t0, 1'b1, 4'd11, 2'd3);
    drive(B_MTI | B_SEI, ALL, '0, '0, 2'd3, 1'b1, 1'b0, 1'b0);
    compare("R8 MTI over SEI", v0, c0, t0, 1'b1, 4'd7, 2'd3);
    drive(B_STI | B_UEI, ALL, '0, '0, 2'd3, 1'b1, 1'b0, 1'b0);
    compare("R8 STI over UEI", v0, c0, t0, 1'b1, 4'd5, 2'd3);
    drive(12'h444, ALL, '0, '0, 2'd3, 1'b1, 1'b0, 1'b0);
    compare("R8 reserved bits ignored", v0, c0, t0, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_supervisor;
    drive(B_SEI, ALL, B_SEI, '0, 2'd1, 1'b1, 1'b1, 1'b0);
    compare("R4 S takes", v0, c0, t0, 1'b1, 4'd9, 2'd1);
    drive(B_SEI, ALL, B_SEI, '0, 2'd1, 1'b1, 1'b0, 1'b0);
    compare("R5 sIe clear in S", v0, c0, t0, 1'b0, 4'd0, 2'd0);
    drive(B_SEI, ALL, B_SEI, '0, 2'd0, 1'b0, 1'b0, 1'b0);
    compare("R5 open from U", v0, c0, t0, 1'b1, 4'd9, 2'd1);
    drive(B_SSI | B_USI, ALL, B_SSI | B_USI, B_USI, 2'd0, 1'b0, 1'b0, 1'b1);
    compare("R4 S before U", v0, c0, t0, 1'b1, 4'd1, 2'd1);
  endtask

  task automatic t_user;
    drive(B_UTI, ALL, B_UTI, B_UTI, 2'd0, 1'b0, 1'b0, 1'b1);
    compare("R6 U takes", v0, c0, t0, 1'b1, 4'd4, 2'd0);
    drive(B_UTI, ALL, B_UTI, B_UTI, 2'd0, 1'b0, 1'b0, 1'b0);
    compare("R7 uIe clear", v0, c0, t0, 1'b0, 4'd0, 2'd0);
    drive(B_UTI, ALL, B_UTI, B_UTI, 2'd1, 1'b0, 1'b1, 1'b1);
    compare("R7 not in U", v0, c0, t0, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_bypass;
    drive(B_SEI, ALL, B_SEI, '0, 2'd3, 1'b0, 1'b0, 1'b0);
    compare("R9 flat hart ignores enables", v1, c1, t1, 1'b1, 4'd9, 2'd3);
    compare("R3 full hart same input", v0, c0, t0, 1'b0, 4'd0, 2'd0);
    drive(B_MEI, '0, '0, '0, 2'd3, 1'b1, 1'b0, 1'b0);
    compare("R9 flat hart fast path", v1, c1, t1, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_no_smode;
    drive(B_SSI, ALL, B_SSI, '0, 2'd0, 1'b0, 1'b0, 1'b1);
    compare("R10 straight to U", v2, c2, t2, 1'b1, 4'd1, 2'd0);
    compare("R4 full hart to S", v0, c0, t0, 1'b1, 4'd1, 2'd1);
    drive(B_UTI, ALL, B_UTI, '0, 2'd0, 1'b0, 1'b0, 1'b0);
    compare("R10 dropped when U closed", v2, c2, t2, 1'b0, 4'd0, 2'd0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    mismatched++;
    compared++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_fast_path();
    t_machine();
    t_priority();
    t_supervisor();
    t_user();
    t_bypass();
    t_no_smode();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule